// File: doc/BRIEF.md
# Register-to-stream word bridge

This block lets software exchange stream frames one 32-bit word at a time. A simple register port (write strobe with address and data, combinational read by address) controls an outgoing AXI4-Stream master and an incoming AXI4-Stream slave. On the transmit side, software loads a word and then writes a one-shot "send" bit. The block turns that single write into a valid/ready handshake that follows the protocol: valid stays asserted and the payload stays stable until the receiver accepts the word. Software polls a ready flag to learn when the next word may be sent.

On the receive side, the block accepts one word into a holding register and then stalls the stream until software has read the word and written a one-shot acknowledge bit. A status register reports whether a word is held and whether it ends a frame. Each direction holds exactly one word.

Register map (word addresses): 0 transmit data, 1 transmit control, 2 transmit status, 3 receive data, 4 receive control, 5 receive status. Addresses 6 and 7 read as zero. In every control and status word the valid/ready flag sits in bit 0 and the end-of-frame flag sits in bit 8.

Top module: `regstream_bridge`

## Requirements
- R1: After reset, m_tvalid is 0 and s_tready is 1. Address 2 reads 0x1. Addresses 0, 1, 3, 4 and 5 read 0.
- R2: Address 0 is a read/write 32-bit transmit data register. A write updates its read value in the next cycle.
- R3: In address 1, bit 8 is a sticky end-of-frame flag that reads back as last written. Bit 0 always reads 0.
- R4: A write to address 1 with bit 0 set, while no word is pending, launches a word. In the next cycle m_tvalid is 1, m_tdata equals the address 0 contents before that write, and m_tlast equals bit 8 of that write.
- R5: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast hold their values, even if software rewrites addresses 0 and 1.
- R6: A word is consumed in a cycle where m_tvalid and m_tready are both 1. m_tvalid is 0 in the next cycle. Bit 0 of address 2 reads 1 exactly when no word is pending.
- R7: A send pulse written while a word is pending is ignored. This includes the cycle in which the pending word is consumed, so m_tvalid is 0 afterwards.
- R8: s_tready is 1 while no word is held. On a handshake the block captures s_tdata and s_tlast. From the next cycle s_tready is 0, address 3 returns the word, and address 5 reads bit 0 = 1 and bit 8 = the captured last flag.
- R9: A write to address 4 with bit 0 set, while a word is held, frees the holding register: s_tready is 1 and bit 0 of address 5 is 0 in the next cycle. The same write while nothing is held changes nothing. Address 4 always reads 0.
- R10: Writes to addresses 2, 3 and 5 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| m_tdata | output | 32 | Outgoing stream data |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tlast | output | 1 | Outgoing stream end of frame |
| m_tready | input | 1 | Outgoing stream ready from receiver |
| s_tdata | input | 32 | Incoming stream data |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tlast | input | 1 | Incoming stream end of frame |
| s_tready | output | 1 | Incoming stream ready |

## Verification
Two transmit-side events can fall on the same clock edge: software writing a send pulse and the receiver consuming the pending word. The bench provokes this by raising m_tready in the very cycle the control write lands. It judges the result by requiring m_tvalid low afterwards and the ready status back at 1. On the receive side, an acknowledge that coincides with a new s_tvalid is also driven. There the rule is that the acknowledge only frees the register and a new capture follows one cycle later. A behavioural model, checked every cycle, covers both cases.

// File: rtl/regstream_pkg.sv
package regstream_pkg;
  localparam int ADDR_W  = 3;
  localparam int FLAG_V  = 0;
  localparam int FLAG_L  = 8;
  localparam int FLAG_W  = FLAG_L + 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_TX_DATA = 3'd0,
    ADR_TX_CTRL = 3'd1,
    ADR_TX_STAT = 3'd2,
    ADR_RX_DATA = 3'd3,
    ADR_RX_CTRL = 3'd4,
    ADR_RX_STAT = 3'd5
  } reg_addr_e;

  function automatic logic [FLAG_W-1:0] flag_word(input logic v, input logic l);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[FLAG_V] = v;
    w[FLAG_L] = l;
    return w;
  endfunction
endpackage

// File: rtl/rsb_reg_decode.sv
module rsb_reg_decode
  import regstream_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] tx_data_q,
  input  logic              tx_last_q,
  input  logic              tx_idle,
  input  logic [DATA_W-1:0] rx_data_q,
  input  logic              rx_full,
  input  logic              rx_last_q,
  output logic              tx_data_we,
  output logic              tx_ctrl_we,
  output logic              tx_send_pulse,
  output logic              rx_ack_pulse,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    tx_data_we    = wr_en && (wr_addr == ADR_TX_DATA);
    tx_ctrl_we    = wr_en && (wr_addr == ADR_TX_CTRL);
    tx_send_pulse = tx_ctrl_we && wr_data[FLAG_V];
    rx_ack_pulse  = wr_en && (wr_addr == ADR_RX_CTRL) && wr_data[FLAG_V];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_TX_DATA: rd_data = tx_data_q;
      ADR_TX_CTRL: rd_data = DATA_W'(flag_word(1'b0, tx_last_q));
      ADR_TX_STAT: rd_data = DATA_W'(flag_word(tx_idle, 1'b0));
      ADR_RX_DATA: rd_data = rx_data_q;
      ADR_RX_STAT: rd_data = DATA_W'(flag_word(rx_full, rx_full & rx_last_q));
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rsb_tx_port.sv
module rsb_tx_port
  import regstream_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              ctrl_we,
  input  logic              send_pulse,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  output logic [DATA_W-1:0] sw_data_q,
  output logic              sw_last_q,
  output logic              idle
);
  logic pend_q;
  logic launch_evt;
  logic retire_evt;

  assign launch_evt = send_pulse && !pend_q;
  assign retire_evt = pend_q && m_tready;
  assign idle       = !pend_q;
  assign m_tvalid   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_data_q <= '0;
      sw_last_q <= 1'b0;
    end else begin
      if (data_we) sw_data_q <= wr_data;
      if (ctrl_we) sw_last_q <= wr_data[FLAG_L];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      m_tdata <= '0;
      m_tlast <= 1'b0;
    end else begin
      if (launch_evt) begin
        pend_q  <= 1'b1;
        m_tdata <= sw_data_q;
        m_tlast <= wr_data[FLAG_L];
      end else if (retire_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> m_tvalid); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R5
  AST_RETIRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready) |=> !m_tvalid); // R7
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready) |=> idle); // R6
endmodule

// File: rtl/rsb_rx_port.sv
module rsb_rx_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_pulse,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [DATA_W-1:0] hold_data_q,
  output logic              hold_last_q,
  output logic              full
);
  logic full_q;
  logic capture_evt;
  logic release_evt;

  assign capture_evt = s_tvalid && !full_q;
  assign release_evt = ack_pulse && full_q;
  assign s_tready    = !full_q;
  assign full        = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q      <= 1'b0;
      hold_data_q <= '0;
      hold_last_q <= 1'b0;
    end else begin
      if (capture_evt) begin
        full_q      <= 1'b1;
        hold_data_q <= s_tdata;
        hold_last_q <= s_tlast;
      end else if (release_evt) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_CAPTURE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |=> (!s_tready && full && hold_data_q == $past(s_tdata))); // R8
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !s_tready) |=> s_tready); // R9
  AST_ACK_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && s_tready && !s_tvalid) |=> (s_tready && $stable(hold_data_q))); // R9
endmodule

// File: rtl/regstream_bridge.sv
module regstream_bridge
  import regstream_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready
);
  logic              tx_data_we, tx_ctrl_we, tx_send_pulse, rx_ack_pulse;
  logic [DATA_W-1:0] tx_data_q, rx_data_q;
  logic              tx_last_q, tx_idle, rx_full, rx_last_q;

  rsb_reg_decode #(.DATA_W(DATA_W)) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .tx_data_q(tx_data_q), .tx_last_q(tx_last_q), .tx_idle(tx_idle),
    .rx_data_q(rx_data_q), .rx_full(rx_full), .rx_last_q(rx_last_q),
    .tx_data_we(tx_data_we), .tx_ctrl_we(tx_ctrl_we),
    .tx_send_pulse(tx_send_pulse), .rx_ack_pulse(rx_ack_pulse),
    .rd_data(rd_data)
  );

  rsb_tx_port #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .data_we(tx_data_we), .ctrl_we(tx_ctrl_we),
    .send_pulse(tx_send_pulse), .wr_data(wr_data), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
    .sw_data_q(tx_data_q), .sw_last_q(tx_last_q), .idle(tx_idle)
  );

  rsb_rx_port #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ack_pulse(rx_ack_pulse),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .hold_data_q(rx_data_q), .hold_last_q(rx_last_q),
    .full(rx_full)
  );

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_TX_STAT || wr_addr == ADR_RX_DATA || wr_addr == ADR_RX_STAT)
     && !m_tvalid && !s_tvalid) |=> (!m_tvalid && $stable(rx_data_q) && $stable(tx_data_q))); // R10
endmodule

// File: tb/regstream_bridge_tb_top.sv
module regstream_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] m_tdata;
  logic        m_tvalid, m_tlast;
  logic        m_tready = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regstream_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .m_tready(m_tready), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready)
  );

  // behavioural model state
  bit          mdl_pend;
  bit [31:0]   mdl_out_data;
  bit          mdl_out_last;
  bit [31:0]   mdl_sw_data;
  bit          mdl_sw_last;
  bit          mdl_full;
  bit [31:0]   mdl_hold_data;
  bit          mdl_hold_last;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return mdl_sw_data;
      3'd1: return {23'd0, mdl_sw_last, 8'd0};
      3'd2: return {31'd0, !mdl_pend};
      3'd3: return mdl_hold_data;
      3'd5: return {23'd0, mdl_full & mdl_hold_last, 7'd0, mdl_full};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_pend = 0; mdl_out_data = 0; mdl_out_last = 0; mdl_sw_data = 0;
      mdl_sw_last = 0; mdl_full = 0; mdl_hold_data = 0; mdl_hold_last = 0;
    end else begin
      bit old_pend;
      bit [31:0] old_sw;
      old_pend = mdl_pend;
      old_sw = mdl_sw_data;
      if (wr_en && wr_addr == 3'd0) mdl_sw_data = wr_data;
      if (wr_en && wr_addr == 3'd1) mdl_sw_last = wr_data[8];
      if (old_pend && m_tready) mdl_pend = 0;
      if (wr_en && wr_addr == 3'd1 && wr_data[0] && !old_pend) begin
        mdl_pend = 1; mdl_out_data = old_sw; mdl_out_last = wr_data[8];
      end
      if (s_tvalid && !mdl_full) begin
        mdl_full = 1; mdl_hold_data = s_tdata; mdl_hold_last = s_tlast;
      end else if (wr_en && wr_addr == 3'd4 && wr_data[0] && mdl_full) begin
        mdl_full = 0;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "m_tvalid", {31'd0, m_tvalid}, {31'd0, mdl_pend});
      if (mdl_pend) begin
        chk("R5", "m_tdata", m_tdata, mdl_out_data);
        chk("R5", "m_tlast", {31'd0, m_tlast}, {31'd0, mdl_out_last});
      end
      chk("R8", "s_tready", {31'd0, s_tready}, {31'd0, !mdl_full});
      chk("R6", $sformatf("rd_data@%0d", rd_addr), rd_data, model_read(rd_addr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, $sformatf("read addr %0d", a), rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk("R1", "m_tvalid", {31'd0, m_tvalid}, 32'd0);
    chk("R1", "s_tready", {31'd0, s_tready}, 32'd1);
    rd_chk("R1", 3'd2, 32'h1);
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd1, 32'h0);
    rd_chk("R1", 3'd3, 32'h0);
    rd_chk("R1", 3'd4, 32'h0);
    rd_chk("R1", 3'd5, 32'h0);

    // R2, R3 register access
    wr(3'd0, 32'hA5A5_0001);
    rd_chk("R2", 3'd0, 32'hA5A5_0001);
    wr(3'd1, 32'h0000_0100);
    rd_chk("R3", 3'd1, 32'h0000_0100);
    chk("R3", "no launch without bit0", {31'd0, m_tvalid}, 32'd0);

    // R4, R5 launch and hold with m_tready low
    wr(3'd1, 32'h0000_0101);
    chk("R4", "m_tvalid after send", {31'd0, m_tvalid}, 32'd1);
    chk("R4", "m_tdata", m_tdata, 32'hA5A5_0001);
    chk("R4", "m_tlast", {31'd0, m_tlast}, 32'd1);
    rd_chk("R3", 3'd1, 32'h0000_0100);
    rd_chk("R6", 3'd2, 32'h0);
    wr(3'd0, 32'h1234_5678);
    wr(3'd1, 32'h0000_0001); // R7 ignored, also clears sticky last
    chk("R5", "m_tdata held", m_tdata, 32'hA5A5_0001);
    chk("R5", "m_tlast held", {31'd0, m_tlast}, 32'd1);
    chk("R7", "still one word", {31'd0, m_tvalid}, 32'd1);
    m_tready = 1;
    step();
    m_tready = 0;
    chk("R6", "m_tvalid after consume", {31'd0, m_tvalid}, 32'd0);
    rd_chk("R6", 3'd2, 32'h1);

    // R7 collision: send pulse in the consume cycle
    wr(3'd1, 32'h0000_0001);
    chk("R4", "second launch data", m_tdata, 32'h1234_5678);
    chk("R4", "second launch last", {31'd0, m_tlast}, 32'd0);
    m_tready = 1;
    wr(3'd1, 32'h0000_0101);
    chk("R7", "collision pulse ignored", {31'd0, m_tvalid}, 32'd0);
    rd_chk("R7", 3'd2, 32'h1);
    // back-to-back with ready high
    wr(3'd1, 32'h0000_0001);
    chk("R4", "launch with ready high", {31'd0, m_tvalid}, 32'd1);
    step();
    chk("R6", "single cycle valid", {31'd0, m_tvalid}, 32'd0);
    m_tready = 0;

    // R8, R9 receive path
    s_tdata = 32'hCAFE_0001; s_tlast = 1; s_tvalid = 1;
    step();
    s_tdata = 32'hCAFE_0002; s_tlast = 0;
    chk("R8", "s_tready low when held", {31'd0, s_tready}, 32'd0);
    rd_chk("R8", 3'd3, 32'hCAFE_0001);
    rd_chk("R8", 3'd5, 32'h0000_0101);
    step();
    rd_chk("R8", 3'd3, 32'hCAFE_0001);
    wr(3'd4, 32'h1); // ack with s_tvalid still high
    chk("R9", "freed", {31'd0, s_tready}, 32'd1);
    rd_chk("R9", 3'd5, 32'h0);
    rd_chk("R9", 3'd4, 32'h0);
    step();
    rd_chk("R8", 3'd3, 32'hCAFE_0002);
    rd_chk("R8", 3'd5, 32'h0000_0001);
    s_tvalid = 0;
    wr(3'd4, 32'h1);
    wr(3'd4, 32'h1); // ack while empty
    chk("R9", "idle ack inert", {31'd0, s_tready}, 32'd1);
    rd_chk("R9", 3'd3, 32'hCAFE_0002);
    rd_chk("R9", 3'd5, 32'h0);

    // R10 writes to read-only addresses
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R10", 3'd3, 32'hCAFE_0002);
    rd_chk("R10", 3'd2, 32'h1);
    rd_chk("R10", 3'd5, 32'h0);
    chk("R10", "no launch", {31'd0, m_tvalid}, 32'd0);

    // mixed traffic, checked by the per-cycle model
    for (int i = 0; i < 60; i++) begin
      m_tready = (i % 3) != 0;
      s_tvalid = (i % 4) != 1;
      s_tdata  = 32'h5000_0000 + i * 7;
      s_tlast  = (i % 5) == 0;
      rd_addr  = 3'(i % 8);
      case (i % 4)
        0: wr(3'd0, 32'h9000_0000 + i);
        1: wr(3'd1, {23'd0, 1'(i % 2), 7'd0, 1'b1});
        2: wr(3'd4, 32'h1);
        default: step();
      endcase
    end
    m_tready = 0; s_tvalid = 0;
    step(); step();
    finish_run();
  end
endmodule